// File: doc/BRIEF.md
# Composite sync and blanking generator

This block sits behind a character-based video timing controller. It takes the controller's raw horizontal and vertical sync pulses, which are active high, and cuts a shorter monitor sync window out of each one. The two monitor syncs are merged into a single composite sync line for the display. The block also drives a blanking request that forces black pixels, and a one-cycle strobe that tells the pixel path to apply a pending video-mode change.

Horizontally, a small counter counts character clocks while raw horizontal sync is high. Monitor horizontal sync is the window of counts from `HS_ON` up to, but not including, `HS_OFF`. The mode-change strobe fires when the count reaches `HS_ON`. Vertically, a line counter starts on the rising edge of raw vertical sync and advances on every end of horizontal sync. Monitor vertical sync is the window of line counts from `VS_ON` up to, but not including, `VS_OFF`. Blanking covers `VBL_LINES` lines and restarts whenever vertical sync rises again.

The horizontal side is a four-state machine: `H_IDLE` (sync low), `H_LEAD` (count below `HS_ON`), `H_PULSE` (monitor horizontal sync window) and `H_HOLD` (count saturated at `HS_OFF`). Its transitions happen only on character-clock samples:
- Any state goes to `H_IDLE` when sync is sampled low.
- `H_IDLE` goes to `H_LEAD` or `H_PULSE` when sync is sampled high.
- The count then walks `H_LEAD` → `H_PULSE` → `H_HOLD`.

The vertical side uses `V_IDLE`, `V_LEAD`, `V_PULSE` and `V_TAIL`:
- A rising vertical sync goes from any state to `V_LEAD`.
- Each line end then walks `V_LEAD` → `V_PULSE` → `V_TAIL`.
- The line end that completes the last blanked line returns the machine to `V_IDLE`.

Top module: `csync_blank_gen`

## Requirements
- R1: After the synchronous reset, `csync_out` is 1 and `mode_commit` is 0. With both raw syncs low, `blank_out` is 0.
- R2: Count each rising clock edge with `char_en`=1 and `hsync_in`=1 as one sample. With vertical blanking idle, `csync_out` is 0 from the 2nd such consecutive sample up to (not including) the 6th. The count is cleared by any `char_en` sample with `hsync_in`=0.
- R3: When `hsync_in` falls, monitor horizontal sync ends at once, even if the count has not reached 6.
- R4: Suppose the 2nd consecutive high sample of `hsync_in` happens with `mode_pend`=1. Then `mode_commit` is 1 for exactly the one clock after that edge. A raw horizontal sync shorter than 2 samples produces no strobe.
- R5: `blank_out` is 1 whenever `hsync_in` is 1, with no delay.
- R6: A line end is a `char_en` sample with `hsync_in`=0 that follows one or more high samples. A vertical sync rise is a `char_en` sample of `vsync_in`=1 after a sample of 0. Monitor vertical sync is active once 2 line ends have occurred since the rise, until the 6th line end.
- R7: `blank_out` is 1 from the clock after a vertical sync rise until the 26th line end completes.
- R8: A new vertical sync rise while blanking is running restarts the line count from 0.
- R9: Composite sync is the XNOR of the two monitor syncs. It is 0 when exactly one of them is active, and 1 when neither or both are active.
- R10: The horizontal count saturates, so a long raw horizontal sync still gives at most 4 characters of monitor sync. A vertical sync held high does not retrigger the blanking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| char_en | input | 1 | Character-clock enable, one clock wide |
| hsync_in | input | 1 | Raw horizontal sync, active high |
| vsync_in | input | 1 | Raw vertical sync, active high |
| mode_pend | input | 1 | A video mode change is waiting |
| csync_out | output | 1 | Composite sync, 0 when active |
| blank_out | output | 1 | Force black pixel output |
| mode_commit | output | 1 | One-clock strobe to apply the pending mode |

## Verification
The bench builds the block with its default parameters:
- horizontal window 2 to 6,
- vertical window 2 to 6,
- 26 blanked lines,
- one character every two clocks.

These values let a short frame reach every corner. It covers raw horizontal sync widths of 1, 2, 3, 4, 5 and 12 characters, and a vertical sync that retriggers in the middle of blanking. It also covers a vertical sync held for longer than the blanking, and the lines where both monitor syncs overlap and the composite returns to 1.

// File: rtl/csbg_pkg.sv
package csbg_pkg;

    typedef enum logic [1:0] {
        H_IDLE,
        H_LEAD,
        H_PULSE,
        H_HOLD
    } hstate_t;

    typedef enum logic [1:0] {
        V_IDLE,
        V_LEAD,
        V_PULSE,
        V_TAIL
    } vstate_t;

endpackage

// File: rtl/csbg_hshape.sv
module csbg_hshape
    import csbg_pkg::*;
#(
    parameter int HS_ON  = 2,
    parameter int HS_OFF = 6,
    localparam int HW    = $clog2(HS_OFF + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          char_en,
    input  logic          hsync_in,
    input  logic          mode_pend,
    output logic          mon_hs,
    output logic          line_end,
    output logic          mode_commit,
    output logic [HW-1:0] hcnt_o
);

    hstate_t       st, st_nx;
    logic [HW-1:0] hcnt, hcnt_nx;
    logic          commit_q;

    function automatic hstate_t classify(input logic [HW-1:0] n);
        if (int'(n) < HS_ON)       return H_LEAD;
        else if (int'(n) < HS_OFF) return H_PULSE;
        else                       return H_HOLD;
    endfunction

    // next-state logic
    always_comb begin
        st_nx   = st;
        hcnt_nx = hcnt;
        if (char_en) begin
            if (!hsync_in) begin
                st_nx   = H_IDLE;
                hcnt_nx = '0;
            end else begin
                if (int'(hcnt) != HS_OFF) hcnt_nx = hcnt + HW'(1);
                st_nx = classify(hcnt_nx);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= H_IDLE;
            hcnt     <= '0;
            commit_q <= 1'b0;
        end else begin
            st       <= st_nx;
            hcnt     <= hcnt_nx;
            commit_q <= char_en && hsync_in && mode_pend && (int'(hcnt) == HS_ON - 1);
        end
    end

    // outputs
    always_comb begin
        mon_hs   = 1'b0;
        line_end = 1'b0;
        unique case (st)
            H_IDLE: begin
                mon_hs   = 1'b0;
                line_end = 1'b0;
            end
            H_LEAD: begin
                mon_hs   = 1'b0;
                line_end = char_en && !hsync_in;
            end
            H_PULSE: begin
                mon_hs   = hsync_in;
                line_end = char_en && !hsync_in;
            end
            H_HOLD: begin
                mon_hs   = 1'b0;
                line_end = char_en && !hsync_in;
            end
            default: begin
                mon_hs   = 1'b0;
                line_end = 1'b0;
            end
        endcase
    end

    assign mode_commit = commit_q;
    assign hcnt_o      = hcnt;

endmodule

// File: rtl/csbg_vshape.sv
module csbg_vshape
    import csbg_pkg::*;
#(
    parameter int VS_ON     = 2,
    parameter int VS_OFF    = 6,
    parameter int VBL_LINES = 26,
    localparam int VW       = $clog2(VBL_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          char_en,
    input  logic          vsync_in,
    input  logic          line_end,
    output logic          mon_vs,
    output logic          vblank,
    output logic [VW-1:0] vcnt_o
);

    vstate_t       st, st_nx;
    logic [VW-1:0] vcnt, vcnt_nx;
    logic          vs_q;
    logic          vrise;

    function automatic vstate_t classify(input logic [VW-1:0] n);
        if (int'(n) < VS_ON)       return V_LEAD;
        else if (int'(n) < VS_OFF) return V_PULSE;
        else                       return V_TAIL;
    endfunction

    assign vrise = char_en && vsync_in && !vs_q;

    // next-state logic: a fresh rise outranks a line end
    always_comb begin
        st_nx   = st;
        vcnt_nx = vcnt;
        if (vrise) begin
            vcnt_nx = '0;
            st_nx   = classify('0);
        end else if (line_end && st != V_IDLE) begin
            if (int'(vcnt) == VBL_LINES - 1) begin
                vcnt_nx = '0;
                st_nx   = V_IDLE;
            end else begin
                vcnt_nx = vcnt + VW'(1);
                st_nx   = classify(vcnt_nx);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= V_IDLE;
            vcnt <= '0;
            vs_q <= 1'b0;
        end else begin
            st   <= st_nx;
            vcnt <= vcnt_nx;
            if (char_en) vs_q <= vsync_in;
        end
    end

    // outputs
    always_comb begin
        mon_vs = 1'b0;
        vblank = 1'b0;
        unique case (st)
            V_IDLE:  begin mon_vs = 1'b0; vblank = 1'b0; end
            V_LEAD:  begin mon_vs = 1'b0; vblank = 1'b1; end
            V_PULSE: begin mon_vs = 1'b1; vblank = 1'b1; end
            V_TAIL:  begin mon_vs = 1'b0; vblank = 1'b1; end
            default: begin mon_vs = 1'b0; vblank = 1'b0; end
        endcase
    end

    assign vcnt_o = vcnt;

endmodule

// File: rtl/csync_blank_gen.sv
module csync_blank_gen #(
    parameter int HS_ON     = 2,
    parameter int HS_OFF    = 6,
    parameter int VS_ON     = 2,
    parameter int VS_OFF    = 6,
    parameter int VBL_LINES = 26
) (
    input  logic clk,
    input  logic rst,
    input  logic char_en,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic mode_pend,
    output logic csync_out,
    output logic blank_out,
    output logic mode_commit
);

    localparam int HW = $clog2(HS_OFF + 1);
    localparam int VW = $clog2(VBL_LINES + 1);

    logic          mon_hs;
    logic          mon_vs;
    logic          line_end;
    logic          vblank;
    logic [HW-1:0] hcnt_w;
    logic [VW-1:0] vcnt_w;

    csbg_hshape #(
        .HS_ON  (HS_ON),
        .HS_OFF (HS_OFF)
    ) u_hshape (
        .clk         (clk),
        .rst         (rst),
        .char_en     (char_en),
        .hsync_in    (hsync_in),
        .mode_pend   (mode_pend),
        .mon_hs      (mon_hs),
        .line_end    (line_end),
        .mode_commit (mode_commit),
        .hcnt_o      (hcnt_w)
    );

    csbg_vshape #(
        .VS_ON     (VS_ON),
        .VS_OFF    (VS_OFF),
        .VBL_LINES (VBL_LINES)
    ) u_vshape (
        .clk      (clk),
        .rst      (rst),
        .char_en  (char_en),
        .vsync_in (vsync_in),
        .line_end (line_end),
        .mon_vs   (mon_vs),
        .vblank   (vblank),
        .vcnt_o   (vcnt_w)
    );

    assign csync_out = ~(mon_hs ^ mon_vs);
    assign blank_out = hsync_in | vblank;

endmodule

// File: rtl/csbg_checker.sv
module csbg_checker #(
    parameter int HS_OFF    = 6,
    parameter int VBL_LINES = 26,
    localparam int HW       = $clog2(HS_OFF + 1),
    localparam int VW       = $clog2(VBL_LINES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          char_en,
    input logic          hsync_in,
    input logic          mode_pend,
    input logic          csync_out,
    input logic          blank_out,
    input logic          mode_commit,
    input logic [HW-1:0] hcnt,
    input logic [VW-1:0] vcnt
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (csync_out && !mode_commit)); // R1

    AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        mode_commit |-> $past(mode_pend && hsync_in && char_en)); // R4

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mode_commit |=> !mode_commit); // R4

    AST_SYNC_BLANKED: assert property (@(posedge clk) disable iff (rst)
        !csync_out |-> blank_out); // R7

    AST_HCNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        int'(hcnt) <= HS_OFF); // R10

    AST_VCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(vcnt) < VBL_LINES); // R7

endmodule

bind csync_blank_gen csbg_checker #(
    .HS_OFF    (HS_OFF),
    .VBL_LINES (VBL_LINES)
) u_csbg_chk (
    .clk         (clk),
    .rst         (rst),
    .char_en     (char_en),
    .hsync_in    (hsync_in),
    .mode_pend   (mode_pend),
    .csync_out   (csync_out),
    .blank_out   (blank_out),
    .mode_commit (mode_commit),
    .hcnt        (hcnt_w),
    .vcnt        (vcnt_w)
);

// File: tb/test_csync_blank_gen.sv
`timescale 1ns/1ps
module test_csync_blank_gen;

    localparam int CHR_DIV = 2;
    localparam int HS_ON   = 2;
    localparam int HS_OFF  = 6;
    localparam int VS_ON   = 2;
    localparam int VS_OFF  = 6;
    localparam int VBL     = 26;
    localparam int LINE_CH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic char_en = 1'b0;
    logic hs = 1'b0;
    logic vs = 1'b0;
    logic pend = 1'b0;
    logic csync, blank, commit;

    always #2 clk = ~clk;

    csync_blank_gen i_csync_blank_gen (
        .clk         (clk),
        .rst         (rst),
        .char_en     (char_en),
        .hsync_in    (hs),
        .vsync_in    (vs),
        .mode_pend   (pend),
        .csync_out   (csync),
        .blank_out   (blank),
        .mode_commit (commit)
    );

    int    checks = 0;
    int    errors = 0;
    string req = "R1";
    bit    active = 1'b0;
    bit    done = 1'b0;

    // behavioural reference model
    int m_h = 0;
    int m_line = -1;
    bit m_vsp = 1'b0;
    bit m_commit = 1'b0;

    always @(posedge clk) begin : model
        bit endl;
        bit rise;
        if (rst) begin
            m_h = 0; m_line = -1; m_vsp = 1'b0; m_commit = 1'b0;
        end else begin
            m_commit = char_en && hs && pend && (m_h == HS_ON - 1);
            if (char_en) begin
                endl  = !hs && (m_h > 0);
                rise  = vs && !m_vsp;
                m_vsp = vs;
                if (hs) begin
                    if (m_h < 1000) m_h++;
                end else begin
                    m_h = 0;
                end
                if (rise) m_line = 0;
                else if (endl && m_line >= 0) begin
                    m_line++;
                    if (m_line == VBL) m_line = -1;
                end
            end
        end
    end

    task automatic chk(input string r, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", r, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin : compare
        bit mhs, mvs;
        #1;
        if (active) begin
            mhs = hs && (m_h >= HS_ON) && (m_h < HS_OFF);
            mvs = (m_line >= VS_ON) && (m_line < VS_OFF);
            chk(req, "csync", csync, !(mhs ^ mvs));
            chk(req, "blank", blank, hs || (m_line >= 0));
            chk(req, "commit", commit, m_commit);
        end
    end

    task automatic chr(input bit h, input bit v);
        for (int i = 0; i < CHR_DIV; i++) begin
            @(negedge clk);
            char_en = (i == 0);
            hs = h;
            vs = v;
        end
    endtask

    task automatic line(input int hs_w, input bit v);
        for (int c = 0; c < LINE_CH; c++)
            chr((c >= 4) && (c < 4 + hs_w), v);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1", "reset csync", csync, 1'b1);
        chk("R1", "reset blank", blank, 1'b0);
        chk("R1", "reset commit", commit, 1'b0);
        active = 1'b1;

        req = "R2/R4/R5"; pend = 1'b1;
        for (int i = 0; i < 3; i++) line(4, 1'b0);
        req = "R3";
        line(3, 1'b0);
        line(5, 1'b0);
        req = "R4";
        line(1, 1'b0);
        line(2, 1'b0);
        pend = 1'b0;
        line(4, 1'b0);
        req = "R10";
        line(12, 1'b0);
        req = "R6/R7/R9"; pend = 1'b1;
        for (int i = 0; i < 6; i++) line(4, 1'b1);
        for (int i = 0; i < 26; i++) line(4, 1'b0);
        req = "R8";
        for (int i = 0; i < 3; i++) line(4, 1'b1);
        for (int i = 0; i < 7; i++) line(4, 1'b0);
        for (int i = 0; i < 3; i++) line(4, 1'b1);
        for (int i = 0; i < 30; i++) line(4, 1'b0);
        req = "R10";
        for (int i = 0; i < 40; i++) line(4, 1'b1);
        for (int i = 0; i < 3; i++) line(4, 1'b0);

        done = 1'b1;
        active = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule